// File: doc/BRIEF.md
# EEPROM Write Controller

This block sits between a CPU register bus and a small on-chip byte EEPROM array, modelled here as registers. Software loads a target address and a data byte, then opens a short unlock window by setting an arm bit. It must then set a go bit before that window closes. Only then does a programming operation start. Each operation runs for a fixed time, counted in clock cycles from a clock-frequency parameter. While it runs, the go bit reads back as one.

Three operations are offered: an atomic erase-and-program, an erase alone and a program alone. The program-alone operation can only clear bits. The block holds off any start while the flash self-programming engine reports busy. It drives a level ready interrupt whenever it is idle, its interrupt enable is set and the global interrupt flag is set.

There are two resets. `por_n` clears everything. `rst_n` is a warm reset. It clears the software-visible registers, but an operation that is already running keeps going and its mode field is kept. The bus has no data stream, so every pin is a plain control or status signal with no handshake. A write is taken on any clock edge where `wr_en` is high, and a read is returned combinationally.

Top module: `eeprom_wr_ctrl`

Register select codes (`wr_sel`, `rd_sel`):
- 0: control register
- 1: address
- 2: data
- 3: the array byte at the current address, read only

Control register bits:
- bit 0: go
- bit 1: arm
- bit 2: interrupt enable
- bits 5:4: mode

## Requirements
- R1: Writing the control register with arm=1 and go=0 sets the arm bit. It reads back as one for exactly four cycles and then clears by itself. A go write taken on any of the four edges after the arm write is accepted. A go write taken on the fifth edge is ignored.
- R2: A control write with go=1 while arm reads zero starts nothing. The go bit stays zero and the array is unchanged.
- R3: The go bit (control bit 0) reads one on every cycle of a programming operation and reads zero whenever the block is idle.
- R4: Mode 00 keeps the go bit set for round-up(CLK_HZ x 3.4 ms) cycles. Modes 01 and 10 keep it set for round-up(CLK_HZ x 1.8 ms) cycles.
- R5: When the operation ends, the addressed byte is updated as follows. Mode 00 stores the data byte. Mode 01 stores 0xFF. Mode 10 stores the old byte AND the data byte.
- R6: A go write with mode code 11 starts nothing and leaves the array unchanged.
- R7: Writes to the mode field (control bits 5:4) are ignored while the go bit reads one.
- R8: A warm reset sets the mode field to 00 if the block is idle. It leaves the mode field alone if an operation is running, and that operation completes. The address, data, interrupt-enable and arm bits clear.
- R9: `ready_irq` is high exactly when the interrupt enable is set, `gie` is high and no operation is running.
- R10: No operation starts while `flash_busy` is high.
- R11: The address and data are captured when the operation starts. Later writes to those registers do not change the operation in progress.
- R12: After power-on reset, every register reads zero, every array byte reads 0xFF and `ready_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register chosen for the write |
| wr_data | input | DATA_W | Write value |
| rd_sel | input | 2 | Register chosen for the read |
| rd_data | output | DATA_W | Read value, combinational |
| flash_busy | input | 1 | Flash self-programming in progress; blocks starts |
| gie | input | 1 | Global interrupt flag |
| ready_irq | output | 1 | Level ready interrupt |

## Verification
The embedded properties check the following on every cycle:
- arm is never high for more than four cycles in a row, and it only rises after an arm request;
- the block never leaves idle while arm is clear or flash is busy;
- the running state holds until its counter ends, and then drops;
- the mode field stays frozen during an operation;
- the interrupt stays silent during an operation;
- a warm reset in idle forces mode 00;
- the reserved code never starts an operation.

Exact durations, the byte produced by each mode, the edges where the unlock window opens and closes, and operand capture against later register writes can only be shown by the bench scenarios, which compare every cycle against a behavioural model.

// File: rtl/eewc_pkg.sv
package eewc_pkg;

  typedef enum logic [1:0] {
    MODE_ATOMIC = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_RSVD   = 2'b11
  } prog_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CELL = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_GO      = 0;
  localparam int unsigned CTL_ARM     = 1;
  localparam int unsigned CTL_IEN     = 2;
  localparam int unsigned CTL_MODE_LO = 4;
  localparam int unsigned CTL_MODE_HI = 5;

endpackage

// File: rtl/eewc_unlock.sv
module eewc_unlock #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_use,
  output logic arm_o
);
  localparam int unsigned TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      arm_o  <= 1'b0;
      left_q <= '0;
    end else if (!rst_n || arm_use) begin
      arm_o  <= 1'b0;
      left_q <= '0;
    end else if (arm_set) begin
      arm_o  <= 1'b1;
      left_q <= TW'(WINDOW - 1);
    end else if (arm_o) begin
      if (left_q == '0) arm_o <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  // checker counter: cycles the arm bit has been high since its last request
  logic [TW:0] held_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       held_q <= '0;
    else if (arm_set) held_q <= (TW+1)'(1);
    else if (arm_o)   held_q <= held_q + 1'b1;
    else              held_q <= '0;
  end

  // R1
  arm_window_chk: assert property (@(posedge clk) disable iff (!por_n)
    arm_o |-> held_q <= (TW+1)'(WINDOW));

  // R1
  arm_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(arm_o) |-> $past(arm_set));

endmodule

// File: rtl/eewc_prog_timer.sv
module eewc_prog_timer
  import eewc_pkg::*;
#(
  parameter int unsigned     CNT_W  = 20,
  parameter longint unsigned T_ATOM = 34,
  parameter longint unsigned T_SPLIT = 18
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       start,
  input  prog_mode_e start_mode,
  output logic       busy_o,
  output logic       done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    if (start_mode == MODE_ATOMIC) load_val = CNT_W'(T_ATOM - 1);
    else                           load_val = CNT_W'(T_SPLIT - 1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    start |=> busy_o);

  // R3
  hold_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    (busy_o && !done_o) |=> busy_o);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    done_o |=> !busy_o);

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy_o |-> !start);

endmodule

// File: rtl/eewc_array.sv
module eewc_array
  import eewc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  prog_mode_e        start_mode,
  input  logic              commit,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] job_addr;
  logic [DATA_W-1:0] job_data;
  prog_mode_e        job_mode;
  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] old_val;
  logic [DATA_W-1:0] new_val;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      job_addr <= '0;
      job_data <= '0;
      job_mode <= MODE_ATOMIC;
    end else if (start) begin
      job_addr <= start_addr;
      job_data <= start_data;
      job_mode <= start_mode;
    end
  end

  assign old_val = cells[job_addr];

  always_comb begin
    case (job_mode)
      MODE_ATOMIC: new_val = job_data;
      MODE_ERASE:  new_val = '1;
      MODE_WRITE:  new_val = old_val & job_data;
      default:     new_val = old_val;
    endcase
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                  q <= '1;
      else if (commit && job_addr == ADDR_W'(i))   q <= new_val;
    end
    assign cells[i] = q;
  end

  assign peek_data = cells[peek_addr];

  // R6
  rsvd_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    start |-> start_mode != MODE_RSVD);

  // R11
  job_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!start && !$past(start)) |-> $stable(job_addr));

endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eewc_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ARM_WINDOW = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flash_busy,
  input  logic              gie,
  output logic              ready_irq
);
  localparam longint unsigned T_ATOM_RAW  = (longint'(CLK_HZ) * 34 + 9999) / 10000;
  localparam longint unsigned T_SPLIT_RAW = (longint'(CLK_HZ) * 18 + 9999) / 10000;
  localparam longint unsigned T_ATOM  = (T_ATOM_RAW  > 0) ? T_ATOM_RAW  : 1;
  localparam longint unsigned T_SPLIT = (T_SPLIT_RAW > 0) ? T_SPLIT_RAW : 1;
  localparam int unsigned     CNT_W   = $clog2(T_ATOM + 1);

  prog_mode_e        mode_q;
  logic              ien_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              arm;
  logic              busy;
  logic              done;
  logic              ctl_wr;
  logic              start;
  logic              arm_set;
  prog_mode_e        req_mode;
  logic [DATA_W-1:0] cell_val;
  logic [DATA_W-1:0] ctrl_rb;

  assign ctl_wr   = wr_en && rst_n && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign req_mode = prog_mode_e'(wr_data[CTL_MODE_HI:CTL_MODE_LO]);
  assign start    = ctl_wr && wr_data[CTL_GO] && arm && !busy && !flash_busy
                    && (req_mode != MODE_RSVD);
  assign arm_set  = ctl_wr && wr_data[CTL_ARM] && !wr_data[CTL_GO];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_ATOMIC;
      ien_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!rst_n) begin
      ien_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      if (!busy) mode_q <= MODE_ATOMIC;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_CTRL: begin
          ien_q <= wr_data[CTL_IEN];
          if (!busy) mode_q <= req_mode;
        end
        SEL_ADDR: addr_q <= wr_data[ADDR_W-1:0];
        SEL_DATA: data_q <= wr_data;
        default: ;
      endcase
    end
  end

  eewc_unlock #(
    .WINDOW (ARM_WINDOW)
  ) u_unlock (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .arm_set (arm_set),
    .arm_use (start),
    .arm_o   (arm)
  );

  eewc_prog_timer #(
    .CNT_W   (CNT_W),
    .T_ATOM  (T_ATOM),
    .T_SPLIT (T_SPLIT)
  ) u_timer (
    .clk        (clk),
    .por_n      (por_n),
    .start      (start),
    .start_mode (req_mode),
    .busy_o     (busy),
    .done_o     (done)
  );

  eewc_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk        (clk),
    .por_n      (por_n),
    .start      (start),
    .start_addr (addr_q),
    .start_data (data_q),
    .start_mode (req_mode),
    .commit     (done),
    .peek_addr  (addr_q),
    .peek_data  (cell_val)
  );

  always_comb begin
    ctrl_rb = '0;
    ctrl_rb[CTL_GO]  = busy;
    ctrl_rb[CTL_ARM] = arm;
    ctrl_rb[CTL_IEN] = ien_q;
    ctrl_rb[CTL_MODE_HI:CTL_MODE_LO] = mode_q;
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CTRL: rd_data = ctrl_rb;
      SEL_ADDR: rd_data = DATA_W'(addr_q);
      SEL_DATA: rd_data = data_q;
      default:  rd_data = cell_val;
    endcase
  end

  assign ready_irq = ien_q && gie && !busy;

  // R2
  no_arm_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!arm && !busy) |=> !busy);

  // R10
  flash_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (flash_busy && !busy) |=> !busy);

  // R7
  mode_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy |=> $stable(mode_q));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !ready_irq);

  // R8
  warm_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !busy) |=> mode_q == MODE_ATOMIC);

endmodule

// File: tb/eeprom_wr_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_wr_ctrl_bench;
  localparam int unsigned HZ = 10000;
  localparam int D_ATOM  = 34;  // 3.4 ms at 10 kHz
  localparam int D_SPLIT = 18;  // 1.8 ms at 10 kHz

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0, wr_en = 1'b0, flash_busy = 1'b0, gie = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        ready_irq;

  int errs = 0, checks = 0;
  logic g_ien = 1'b0;

  eeprom_wr_ctrl #(.CLK_HZ(HZ), .ADDR_W(4), .DATA_W(8), .ARM_WINDOW(4)) u_eeprom_wr_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .flash_busy(flash_busy),
    .gie(gie), .ready_irq(ready_irq));

  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit   m_arm, m_busy, m_ien;
  int   m_left, m_cnt, m_mode, j_mode;
  logic [3:0] m_addr, j_addr;
  logic [7:0] m_data, j_data;
  logic [7:0] arr [16];

  always @(posedge clk) begin : model
    bit ob, oa;
    if (!por_n) begin
      m_arm = 0; m_busy = 0; m_ien = 0; m_left = 0; m_cnt = 0; m_mode = 0;
      m_addr = 0; m_data = 0; j_mode = 0; j_addr = 0; j_data = 0;
      for (int i = 0; i < 16; i++) arr[i] = 8'hFF;
    end else begin
      ob = m_busy; oa = m_arm;
      if (m_busy) begin
        if (m_cnt == 0) begin
          if (j_mode == 0)      arr[j_addr] = j_data;
          else if (j_mode == 1) arr[j_addr] = 8'hFF;
          else                  arr[j_addr] = arr[j_addr] & j_data;
          m_busy = 0;
        end else m_cnt--;
      end
      if (m_arm) begin
        if (m_left == 0) m_arm = 0; else m_left--;
      end
      if (!rst_n) begin
        m_arm = 0; m_ien = 0; m_addr = 0; m_data = 0;
        if (!ob) m_mode = 0;
      end else if (wr_en) begin
        if (wr_sel == 2'd0) begin
          if (!ob) m_mode = int'(wr_data[5:4]);
          m_ien = wr_data[2];
          if (wr_data[0]) begin
            if (oa && !ob && !flash_busy && wr_data[5:4] != 2'b11) begin
              m_busy = 1; m_arm = 0;
              m_cnt = ((wr_data[5:4] == 2'b00) ? D_ATOM : D_SPLIT) - 1;
              j_addr = m_addr; j_data = m_data; j_mode = int'(wr_data[5:4]);
            end
          end else if (wr_data[1]) begin
            m_arm = 1; m_left = 3;
          end
        end else if (wr_sel == 2'd1) m_addr = wr_data[3:0];
        else if (wr_sel == 2'd2)     m_data = wr_data;
      end
    end
  end

  // per-cycle comparison, well after the edge
  always @(posedge clk) begin
    #2;
    if (por_n) begin
      logic [7:0] exp;
      case (rd_sel)
        2'd0: exp = {2'b00, 2'(m_mode), 1'b0, m_ien, m_arm, m_busy};
        2'd1: exp = {4'h0, m_addr};
        2'd2: exp = m_data;
        default: exp = arr[m_addr];
      endcase
      chk(rd_sel == 2'd0 ? "R3" : (rd_sel == 2'd3 ? "R5" : "R11"), "model readback", rd_data, exp);
      chk("R9", "model irq", ready_irq, m_ien && gie && !m_busy);
    end
  end

  function automatic logic [7:0] ctl(logic [1:0] md, logic ie, logic arm, logic go);
    return {2'b00, md, 1'b0, ie, arm, go};
  endfunction

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(logic [1:0] sel, output logic [7:0] v);
    rd_sel = sel; #0.5; v = rd_data; rd_sel = 2'd0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    peek(2'd0, v);
    while (v[0]) begin @(negedge clk); peek(2'd0, v); end
  endtask

  task automatic run_op(logic [3:0] a, logic [7:0] d, logic [1:0] md, output int dur);
    logic [7:0] v;
    wr(2'd1, {4'h0, a}); wr(2'd2, d);
    wr(2'd0, ctl(md, g_ien, 1'b1, 1'b0));
    wr(2'd0, ctl(md, g_ien, 1'b0, 1'b1));
    dur = 0;
    peek(2'd0, v);
    while (v[0]) begin dur++; @(negedge clk); peek(2'd0, v); end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int dur;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    peek(2'd0, v); chk("R12", "ctrl after por", v, 8'h00);
    peek(2'd3, v); chk("R12", "cell after por", v, 8'hFF);
    chk("R12", "irq after por", ready_irq, 1'b0);

    // R1 arm self-clears after four cycles
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    peek(2'd0, v); chk("R1", "arm first cycle", v[1], 1'b1);
    idle(3); peek(2'd0, v); chk("R1", "arm fourth cycle", v[1], 1'b1);
    idle(1); peek(2'd0, v); chk("R1", "arm fifth cycle", v[1], 1'b0);

    // R1 go on fifth edge ignored
    wr(2'd1, 8'h05); wr(2'd2, 8'h33);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    idle(4);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    peek(2'd0, v); chk("R1", "late go ignored", v[0], 1'b0);
    peek(2'd3, v); chk("R1", "late go cell", v, 8'hFF);

    // R1 go on fourth edge accepted
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    idle(3);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    peek(2'd0, v); chk("R1", "edge go accepted", v[0], 1'b1);
    wait_idle();
    peek(2'd3, v); chk("R1", "edge go cell", v, 8'h33);

    // R2 go without arm
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    peek(2'd0, v); chk("R2", "go without arm", v[0], 1'b0);

    // R4 R5 atomic
    run_op(4'd3, 8'h5A, 2'b00, dur);
    chk("R4", "atomic duration", dur, D_ATOM);
    peek(2'd3, v); chk("R5", "atomic result", v, 8'h5A);

    // R4 R5 program only
    run_op(4'd3, 8'h0F, 2'b10, dur);
    chk("R4", "write-only duration", dur, D_SPLIT);
    peek(2'd3, v); chk("R5", "write-only AND", v, 8'h0A);

    // R4 R5 erase only
    run_op(4'd3, 8'h00, 2'b01, dur);
    chk("R4", "erase duration", dur, D_SPLIT);
    peek(2'd3, v); chk("R5", "erase result", v, 8'hFF);

    // R6 reserved code
    run_op(4'd7, 8'h12, 2'b11, dur);
    chk("R6", "reserved no run", dur, 0);
    peek(2'd3, v); chk("R6", "reserved cell", v, 8'hFF);

    // R11 capture at start
    wr(2'd1, 8'h09); wr(2'd2, 8'hC3);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    wr(2'd1, 8'h02); wr(2'd2, 8'h00);
    wait_idle();
    peek(2'd3, v); chk("R11", "other cell untouched", v, 8'hFF);
    wr(2'd1, 8'h09);
    peek(2'd3, v); chk("R11", "captured operands", v, 8'hC3);

    // R7 mode frozen while busy
    wr(2'd1, 8'h04); wr(2'd2, 8'h11);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    wr(2'd0, ctl(2'b11, 1'b0, 1'b0, 1'b0));
    peek(2'd0, v); chk("R7", "mode kept while busy", v[5:4], 2'b00);
    chk("R3", "busy during op", v[0], 1'b1);
    wait_idle();

    // R9 ready interrupt
    gie = 1'b1; g_ien = 1'b1;
    wr(2'd0, ctl(2'b00, 1'b1, 1'b0, 1'b0));
    chk("R9", "irq idle enabled", ready_irq, 1'b1);
    wr(2'd1, 8'h08); wr(2'd2, 8'h44);
    wr(2'd0, ctl(2'b00, 1'b1, 1'b1, 1'b0));
    wr(2'd0, ctl(2'b00, 1'b1, 1'b0, 1'b1));
    chk("R9", "irq low while busy", ready_irq, 1'b0);
    wait_idle();
    chk("R9", "irq back after op", ready_irq, 1'b1);
    gie = 1'b0; #0.5;
    chk("R9", "irq gated by gie", ready_irq, 1'b0);
    g_ien = 1'b0;

    // R10 flash busy blocks
    flash_busy = 1'b1;
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1));
    peek(2'd0, v); chk("R10", "flash busy blocks", v[0], 1'b0);
    flash_busy = 1'b0;
    idle(5);

    // R8 warm reset in idle and during an operation
    wr(2'd0, ctl(2'b10, 1'b0, 1'b0, 1'b0));
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    peek(2'd0, v); chk("R8", "idle warm reset mode", v[5:4], 2'b00);
    wr(2'd1, 8'h06); wr(2'd2, 8'h0F);
    wr(2'd0, ctl(2'b10, 1'b0, 1'b1, 1'b0));
    wr(2'd0, ctl(2'b10, 1'b0, 1'b0, 1'b1));
    idle(3);
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    peek(2'd0, v); chk("R8", "busy warm reset mode", v[5:4], 2'b10);
    chk("R8", "op survives warm reset", v[0], 1'b1);
    peek(2'd1, v); chk("R8", "addr cleared", v, 8'h00);
    wait_idle();
    wr(2'd1, 8'h06);
    peek(2'd3, v); chk("R8", "op completed", v, 8'h0F);

    idle(2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule